// File: doc/BRIEF.md
# USB Full-Speed Transceiver Mode Controller

This block is the digital control side of a full-speed USB transceiver. It sits between a link-layer controller on the logic side and the analog line drivers and receivers on the cable side. The logic side provides an active-low transmit enable, a suspend request, an attach (pull-up) request, and two single-ended data pins. These pins carry drive data into the block while transmitting and show the sampled line levels while receiving. The cable side sees digital D+/D- drive values, a shared driver enable, and the sampled D+/D- levels.

Every control and line input is resynchronised through a two-stage flop chain. The block then decodes the operating mode from the synchronised suspend, transmit-enable and supply-absent inputs. It passes the single-ended drive code to the line. It derives a differential receive bit that keeps its last value through single-ended-zero and single-ended-one line states. A bus-voltage-present flag is built from two comparator inputs with hysteresis. Absence of the I/O supply puts the whole block in a safe disabled state.

Top module: `usbfs_xcvr_ctrl`

## Requirements
- R1: While reset is asserted: the line driver enable, line outputs, pull-up enable, receive output, bus-voltage flag, illegal-code flag and single-ended pin values are 0, and the single-ended pin direction output is 1. The held receive value leaves reset as 1, so a single-ended-zero line seen first after reset gives a receive output of 1.
- R2: Input changes reach the decoded outputs on the second rising edge after they are applied. The bus-voltage flag and the illegal-code flag update one edge later.
- R3: The line driver enable is 1 only when transmit enable (active low) is 0, the supply-absent input is 0, and either bus-powered operation is off or the bus-voltage flag output is 1.
- R4: While the driver is enabled, the drive code {dm,dp} is placed on the line: 00 gives both lines 0 (SE0), 01 gives D+=1 D-=0, 10 gives D+=0 D-=1, and 11 gives both lines 1. While the driver is released, both line outputs are 0.
- R5: The single-ended pin direction output is 1 (pins driven by the block) exactly when transmit enable is 1 or the supply is absent. Driven pins show the sampled D+ and D- levels, or 0 when the supply is absent. Undriven pin values are 0.
- R6: With suspend and supply-absent both 0, a differential line state (D+ differs from D-) sets the receive output to the D+ level.
- R7: A SE0 or SE1 line state leaves the receive output at its last differential value.
- R8: Suspend forces the receive output to 0 and freezes the held value, so the value from before suspend returns when suspend ends on a non-differential line.
- R9: The bus-voltage state is set by the above-high comparator and cleared by the below-low comparator. It holds when neither is asserted, and clearing wins when both are asserted.
- R10: The bus-voltage flag output is 1 whenever suspend is 1 and the supply is present, and otherwise equals the hysteresis state.
- R11: With the supply absent, the driver enable, pull-up enable, receive output, bus-voltage flag and single-ended pin values are all 0.
- R12: The pull-up enable equals the attach input while the supply is present.
- R13: The illegal-code flag is 1 for exactly one cycle when the 11 drive code begins while the driver is enabled. It stays 0 for code 11 while the driver is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n_i | input | 1 | Transmit enable, active low |
| suspend_i | input | 1 | Low-power request |
| attach_i | input | 1 | Pull-up (attach) request |
| io_absent_i | input | 1 | I/O supply missing, selects disabled state |
| bus_pwr_i | input | 1 | Bus-powered operation, gates drive on the bus-voltage flag |
| sep_dp_i | input | 1 | Single-ended D+ pin value from the logic side (drive code bit 0) |
| sep_dm_i | input | 1 | Single-ended D- pin value from the logic side (drive code bit 1) |
| sep_dp_o | output | 1 | Single-ended D+ pin value driven by the block |
| sep_dm_o | output | 1 | Single-ended D- pin value driven by the block |
| sep_oe_o | output | 1 | 1 when the block drives the single-ended pins |
| bus_dp_i | input | 1 | Sampled D+ line level |
| bus_dm_i | input | 1 | Sampled D- line level |
| bus_dp_o | output | 1 | D+ drive value |
| bus_dm_o | output | 1 | D- drive value |
| bus_drv_o | output | 1 | Line driver enable |
| vb_above_i | input | 1 | Comparator: bus voltage above the upper threshold |
| vb_below_i | input | 1 | Comparator: bus voltage below the lower threshold |
| rcv_o | output | 1 | Differential receive output |
| vbus_ok_o | output | 1 | Bus-voltage-present flag |
| pullup_o | output | 1 | Pull-up switch enable |
| bad_code_o | output | 1 | One-cycle pulse on entry into the illegal drive code |

## Verification
The bench sweeps every combination of supply, suspend, transmit enable, attach, bus-powered mode, drive code and line state under both bus-voltage states. It tracks the held receive bit in its own model. A design that cleared or updated the held bit on SE0/SE1 would show a receive output that does not match the model. So would a design that updated the held bit during suspend. Directed sequences drive the hysteresis comparators through set, hold, clear and the both-asserted case, where a design with set priority would leave the flag high. The illegal-code pulse is timed edge by edge, which catches a level output instead of a pulse. It also catches a pulse raised while the driver is released. The first receive output after reset on an SE0 line exposes a held value reset to 0.

// File: rtl/usbx_pkg.sv
package usbx_pkg;

  // bit positions inside the synchroniser bundle
  localparam int B_TXN   = 0;
  localparam int B_SUSP  = 1;
  localparam int B_ATT   = 2;
  localparam int B_OFF   = 3;
  localparam int B_BPWR  = 4;
  localparam int B_SDP   = 5;
  localparam int B_SDM   = 6;
  localparam int B_LDP   = 7;
  localparam int B_LDM   = 8;
  localparam int B_VHI   = 9;
  localparam int B_VLO   = 10;
  localparam int IN_W    = 11;

  // safe values held by the synchroniser while in reset:
  // transmit disabled and supply treated as absent
  localparam logic [IN_W-1:0] IN_RST = (IN_W'(1) << B_TXN) | (IN_W'(1) << B_OFF);

  typedef enum logic [2:0] {
    MODE_DISABLED,
    MODE_TX_RX,
    MODE_RX_ONLY,
    MODE_TX_SUSP,
    MODE_LOW_POWER
  } xmode_e;

  typedef struct packed {
    logic drive;     // line drivers enabled
    logic rx_on;     // differential receiver active
    logic pins_out;  // single-ended pins driven by this block
    logic off;       // supply-absent state
  } mode_ctl_t;

endpackage

// File: rtl/usbx_sync.sv
module usbx_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/usbx_mode_dec.sv
module usbx_mode_dec
  import usbx_pkg::*;
(
  input  logic      off_i,
  input  logic      susp_i,
  input  logic      tx_en_n_i,
  input  logic      bus_pwr_i,
  input  logic      vbus_flag_i,
  output xmode_e    mode_o,
  output mode_ctl_t ctl_o
);

  logic vbus_gate;

  always_comb begin
    if (off_i)                       mode_o = MODE_DISABLED;
    else if (!susp_i && !tx_en_n_i)  mode_o = MODE_TX_RX;
    else if (!susp_i)                mode_o = MODE_RX_ONLY;
    else if (!tx_en_n_i)             mode_o = MODE_TX_SUSP;
    else                             mode_o = MODE_LOW_POWER;
  end

  // bus-powered operation releases the line while bus voltage is missing
  assign vbus_gate = !bus_pwr_i || vbus_flag_i;

  always_comb begin
    ctl_o = '0;
    unique case (mode_o)
      MODE_DISABLED: begin
        ctl_o.off      = 1'b1;
        ctl_o.pins_out = 1'b1;
      end
      MODE_TX_RX: begin
        ctl_o.drive = vbus_gate;
        ctl_o.rx_on = 1'b1;
      end
      MODE_RX_ONLY: begin
        ctl_o.rx_on    = 1'b1;
        ctl_o.pins_out = 1'b1;
      end
      MODE_TX_SUSP: begin
        ctl_o.drive = vbus_gate;
      end
      MODE_LOW_POWER: begin
        ctl_o.pins_out = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/usbx_rx_hold.sv
module usbx_rx_hold #(
  parameter logic HOLD_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_on_i,
  input  logic dp_i,
  input  logic dm_i,
  output logic rcv_o
);

  logic held_q, held_d;
  logic diff;

  assign diff = dp_i ^ dm_i;

  always_comb begin
    held_d = held_q;
    if (rx_on_i && diff) held_d = dp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= HOLD_RST;
    else        held_q <= held_d;
  end

  always_comb begin
    if (!rx_on_i)  rcv_o = 1'b0;
    else if (diff) rcv_o = dp_i;
    else           rcv_o = held_q;
  end

endmodule

// File: rtl/usbx_vbus_mon.sv
module usbx_vbus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic above_i,
  input  logic below_i,
  input  logic susp_i,
  input  logic off_i,
  output logic state_o,
  output logic flag_o
);

  logic st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (below_i)      st_d = 1'b0;
    else if (above_i) st_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  always_comb begin
    if (off_i)       flag_o = 1'b0;
    else if (susp_i) flag_o = 1'b1;
    else             flag_o = st_q;
  end

endmodule

// File: rtl/usbx_line_drv.sv
module usbx_line_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_i,
  input  logic code_dp_i,
  input  logic code_dm_i,
  output logic line_dp_o,
  output logic line_dm_o,
  output logic bad_o
);

  logic bad_now, bad_prev_q, bad_q;
  logic bad_q_d, bad_prev_d;

  always_comb begin
    line_dp_o = 1'b0;
    line_dm_o = 1'b0;
    if (drive_i) begin
      unique case ({code_dm_i, code_dp_i})
        2'b00:   begin line_dp_o = 1'b0; line_dm_o = 1'b0; end
        2'b01:   begin line_dp_o = 1'b1; line_dm_o = 1'b0; end
        2'b10:   begin line_dp_o = 1'b0; line_dm_o = 1'b1; end
        default: begin line_dp_o = 1'b1; line_dm_o = 1'b1; end
      endcase
    end
  end

  assign bad_now    = drive_i && code_dp_i && code_dm_i;
  assign bad_q_d    = bad_now && !bad_prev_q;
  assign bad_prev_d = bad_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q      <= 1'b0;
      bad_prev_q <= 1'b0;
    end else begin
      bad_q      <= bad_q_d;
      bad_prev_q <= bad_prev_d;
    end
  end

  assign bad_o = bad_q;

endmodule

// File: rtl/usbfs_xcvr_ctrl.sv
module usbfs_xcvr_ctrl
  import usbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_n_i,
  input  logic suspend_i,
  input  logic attach_i,
  input  logic io_absent_i,
  input  logic bus_pwr_i,
  input  logic sep_dp_i,
  input  logic sep_dm_i,
  output logic sep_dp_o,
  output logic sep_dm_o,
  output logic sep_oe_o,
  input  logic bus_dp_i,
  input  logic bus_dm_i,
  output logic bus_dp_o,
  output logic bus_dm_o,
  output logic bus_drv_o,
  input  logic vb_above_i,
  input  logic vb_below_i,
  output logic rcv_o,
  output logic vbus_ok_o,
  output logic pullup_o,
  output logic bad_code_o
);

  logic [IN_W-1:0] raw_in, s_in;
  logic      s_txn, s_susp, s_att, s_off, s_bpwr;
  logic      s_sdp, s_sdm, s_ldp, s_ldm, s_vhi, s_vlo;
  xmode_e    mode;
  mode_ctl_t ctl;
  logic      vb_flag, vb_state;

  always_comb begin
    raw_in         = '0;
    raw_in[B_TXN]  = tx_en_n_i;
    raw_in[B_SUSP] = suspend_i;
    raw_in[B_ATT]  = attach_i;
    raw_in[B_OFF]  = io_absent_i;
    raw_in[B_BPWR] = bus_pwr_i;
    raw_in[B_SDP]  = sep_dp_i;
    raw_in[B_SDM]  = sep_dm_i;
    raw_in[B_LDP]  = bus_dp_i;
    raw_in[B_LDM]  = bus_dm_i;
    raw_in[B_VHI]  = vb_above_i;
    raw_in[B_VLO]  = vb_below_i;
  end

  usbx_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (s_in)
  );

  assign s_txn  = s_in[B_TXN];
  assign s_susp = s_in[B_SUSP];
  assign s_att  = s_in[B_ATT];
  assign s_off  = s_in[B_OFF];
  assign s_bpwr = s_in[B_BPWR];
  assign s_sdp  = s_in[B_SDP];
  assign s_sdm  = s_in[B_SDM];
  assign s_ldp  = s_in[B_LDP];
  assign s_ldm  = s_in[B_LDM];
  assign s_vhi  = s_in[B_VHI];
  assign s_vlo  = s_in[B_VLO];

  usbx_vbus_mon u_vbus (
    .clk     (clk),
    .rst_n   (rst_n),
    .above_i (s_vhi),
    .below_i (s_vlo),
    .susp_i  (s_susp),
    .off_i   (s_off),
    .state_o (vb_state),
    .flag_o  (vb_flag)
  );

  usbx_mode_dec u_mode (
    .off_i       (s_off),
    .susp_i      (s_susp),
    .tx_en_n_i   (s_txn),
    .bus_pwr_i   (s_bpwr),
    .vbus_flag_i (vb_flag),
    .mode_o      (mode),
    .ctl_o       (ctl)
  );

  usbx_line_drv u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_i   (ctl.drive),
    .code_dp_i (s_sdp),
    .code_dm_i (s_sdm),
    .line_dp_o (bus_dp_o),
    .line_dm_o (bus_dm_o),
    .bad_o     (bad_code_o)
  );

  usbx_rx_hold #(.HOLD_RST(1'b1)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_on_i (ctl.rx_on),
    .dp_i    (s_ldp),
    .dm_i    (s_ldm),
    .rcv_o   (rcv_o)
  );

  assign bus_drv_o = ctl.drive;
  assign sep_oe_o  = ctl.pins_out;
  assign sep_dp_o  = ctl.pins_out && !ctl.off && s_ldp;
  assign sep_dm_o  = ctl.pins_out && !ctl.off && s_ldm;
  assign pullup_o  = s_att && !ctl.off;
  assign vbus_ok_o = vb_flag;

endmodule

// File: rtl/usbfs_xcvr_ctrl_chk.sv
module usbfs_xcvr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic s_off,
  input logic s_ldp,
  input logic s_ldm,
  input logic s_vhi,
  input logic s_vlo,
  input logic rx_on,
  input logic vb_state,
  input logic sep_oe_o,
  input logic bus_dp_o,
  input logic bus_dm_o,
  input logic bus_drv_o,
  input logic rcv_o,
  input logic vbus_ok_o,
  input logic pullup_o,
  input logic bad_code_o
);

  // R4: released line carries no drive value
  p_release_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drv_o |-> (!bus_dp_o && !bus_dm_o));

  // R5: pins never driven by the block while it drives the line
  p_pin_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv_o |-> !sep_oe_o);

  // R7: non-differential line keeps the receive output steady
  p_rcv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && $past(rx_on) && (s_ldp == s_ldm)) |-> (rcv_o == $past(rcv_o)));

  // R9: hysteresis holds with no comparator active
  p_vb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_vhi && !s_vlo) |=> $stable(vb_state));

  // R9: clear wins
  p_vb_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_vlo |=> !vb_state);

  // R11: supply absent silences everything
  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s_off |-> (!bus_drv_o && !pullup_o && !rcv_o && !vbus_ok_o));

  // R13: illegal flag is a single-cycle pulse
  p_bad_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code_o |=> !bad_code_o);

endmodule

bind usbfs_xcvr_ctrl usbfs_xcvr_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_off      (s_off),
  .s_ldp      (s_ldp),
  .s_ldm      (s_ldm),
  .s_vhi      (s_vhi),
  .s_vlo      (s_vlo),
  .rx_on      (ctl.rx_on),
  .vb_state   (vb_state),
  .sep_oe_o   (sep_oe_o),
  .bus_dp_o   (bus_dp_o),
  .bus_dm_o   (bus_dm_o),
  .bus_drv_o  (bus_drv_o),
  .rcv_o      (rcv_o),
  .vbus_ok_o  (vbus_ok_o),
  .pullup_o   (pullup_o),
  .bad_code_o (bad_code_o)
);

// File: tb/usbfs_xcvr_ctrl_test.sv
module usbfs_xcvr_ctrl_test;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en_n, susp, att, off, bpwr, sdp, sdm, ldp, ldm, vhi, vlo;
  logic sep_dp_o, sep_dm_o, sep_oe_o, bus_dp_o, bus_dm_o, bus_drv_o;
  logic rcv_o, vbus_ok_o, pullup_o, bad_code_o;

  int checks = 0;
  int errors = 0;
  logic m_held;
  logic m_vb;

  always #10 clk = ~clk;

  usbfs_xcvr_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .tx_en_n_i(tx_en_n), .suspend_i(susp), .attach_i(att),
    .io_absent_i(off), .bus_pwr_i(bpwr),
    .sep_dp_i(sdp), .sep_dm_i(sdm),
    .sep_dp_o(sep_dp_o), .sep_dm_o(sep_dm_o), .sep_oe_o(sep_oe_o),
    .bus_dp_i(ldp), .bus_dm_i(ldm),
    .bus_dp_o(bus_dp_o), .bus_dm_o(bus_dm_o), .bus_drv_o(bus_drv_o),
    .vb_above_i(vhi), .vb_below_i(vlo),
    .rcv_o(rcv_o), .vbus_ok_o(vbus_ok_o), .pullup_o(pullup_o),
    .bad_code_o(bad_code_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all();
    logic e_vb, e_drv, e_rcv;
    e_vb  = off ? 1'b0 : (susp ? 1'b1 : m_vb);
    e_drv = !off && !tx_en_n && (!bpwr || e_vb);
    if (!off && !susp && (ldp != ldm)) m_held = ldp;
    e_rcv = (off || susp) ? 1'b0 : ((ldp != ldm) ? ldp : m_held);
    chk("R10", "vbus_ok", vbus_ok_o, e_vb);
    chk("R3",  "bus_drv", bus_drv_o, e_drv);
    chk("R4",  "bus_dp",  bus_dp_o,  e_drv && sdp);
    chk("R4",  "bus_dm",  bus_dm_o,  e_drv && sdm);
    chk("R5",  "sep_oe",  sep_oe_o,  off || tx_en_n);
    chk("R5",  "sep_dp",  sep_dp_o,  !off && tx_en_n && ldp);
    chk("R5",  "sep_dm",  sep_dm_o,  !off && tx_en_n && ldm);
    chk("R12", "pullup",  pullup_o,  att && !off);
    chk("R6",  "rcv",     rcv_o,     e_rcv);
    chk("R13", "bad_code steady", bad_code_o, 1'b0);
  endtask

  task automatic set_vb(input logic v);
    vhi = v; vlo = !v;
    wait_clks(5);
    vhi = 1'b0; vlo = 1'b0;
    wait_clks(5);
    m_vb = v;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_en_n = 1'b0; susp = 1'b0; att = 1'b1; off = 1'b0; bpwr = 1'b0;
    sdp = 1'b1; sdm = 1'b1; ldp = 1'b0; ldm = 1'b0; vhi = 1'b1; vlo = 1'b0;
    m_held = 1'b1; m_vb = 1'b0;
    wait_clks(3);
    // R1: reset state with every input pushing outputs active
    chk("R1", "rst bus_drv", bus_drv_o, 1'b0);
    chk("R1", "rst bus_dp", bus_dp_o, 1'b0);
    chk("R1", "rst pullup", pullup_o, 1'b0);
    chk("R1", "rst rcv", rcv_o, 1'b0);
    chk("R1", "rst vbus_ok", vbus_ok_o, 1'b0);
    chk("R1", "rst bad_code", bad_code_o, 1'b0);
    chk("R1", "rst sep_oe", sep_oe_o, 1'b1);
    chk("R1", "rst sep_dp", sep_dp_o, 1'b0);
    vhi = 1'b0; sdp = 1'b0; sdm = 1'b0;
    tx_en_n = 1'b1;
    rst_n = 1'b1;
    // R2: two edges to propagate, SE0 line gives held reset value 1 (R1)
    @(posedge clk); @(negedge clk);
    chk("R2", "pullup after 1 edge", pullup_o, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R2", "pullup after 2 edges", pullup_o, 1'b1);
    chk("R1", "held reset value on SE0", rcv_o, 1'b1);

    // R9 / R10: hysteresis sequence
    vhi = 1'b1; @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2", "vbus before 3rd edge", vbus_ok_o, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9", "set by above", vbus_ok_o, 1'b1);
    vhi = 1'b0; wait_clks(5);
    chk("R9", "hold high", vbus_ok_o, 1'b1);
    vlo = 1'b1; wait_clks(5);
    chk("R9", "clear by below", vbus_ok_o, 1'b0);
    vlo = 1'b0; wait_clks(5);
    chk("R9", "hold low", vbus_ok_o, 1'b0);
    susp = 1'b1; wait_clks(4);
    chk("R10", "suspend forces flag", vbus_ok_o, 1'b1);
    susp = 1'b0;
    vhi = 1'b1; vlo = 1'b1; wait_clks(5);
    chk("R9", "both asserted clears", vbus_ok_o, 1'b0);
    vhi = 1'b0; vlo = 1'b0; wait_clks(5);
    m_vb = 1'b0;

    // R7 / R8: hold through SE0, SE1 and suspend
    ldp = 1'b0; ldm = 1'b1; wait_clks(4);
    chk("R6", "diff 0", rcv_o, 1'b0);
    ldp = 1'b1; ldm = 1'b1; wait_clks(4);
    chk("R7", "SE1 holds 0", rcv_o, 1'b0);
    ldp = 1'b1; ldm = 1'b0; wait_clks(4);
    chk("R6", "diff 1", rcv_o, 1'b1);
    ldp = 1'b0; ldm = 1'b0; wait_clks(4);
    chk("R7", "SE0 holds 1", rcv_o, 1'b1);
    susp = 1'b1; ldp = 1'b0; ldm = 1'b1; wait_clks(4);
    chk("R8", "suspend forces low", rcv_o, 1'b0);
    ldp = 1'b0; ldm = 1'b0; wait_clks(4);
    susp = 1'b0; wait_clks(4);
    chk("R8", "held survives suspend", rcv_o, 1'b1);
    m_held = 1'b1;

    // R13: illegal pulse timing
    bpwr = 1'b0; tx_en_n = 1'b0; sdp = 1'b1; sdm = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R13", "no pulse before 3rd edge", bad_code_o, 1'b0);
    chk("R4", "code 11 drives both", bus_dp_o && bus_dm_o, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R13", "pulse on 3rd edge", bad_code_o, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R13", "pulse ends", bad_code_o, 1'b0);
    sdp = 1'b0; wait_clks(5);
    tx_en_n = 1'b1; sdp = 1'b1; wait_clks(2);
    for (int i = 0; i < 4; i++) begin
      chk("R13", "no pulse while released", bad_code_o, 1'b0);
      @(negedge clk);
    end

    // exhaustive sweep: R3 R4 R5 R6 R7 R10 R11 R12
    for (int v = 0; v < 2; v++) begin
      set_vb(v[0]);
      for (int k = 0; k < 512; k++) begin
        logic [8:0] b;
        b = k[8:0];
        off = b[8]; susp = b[7]; tx_en_n = b[6]; att = b[5]; bpwr = b[4];
        sdm = b[3]; sdp = b[2]; ldm = b[1]; ldp = b[0];
        wait_clks(4);
        check_all();
        if (off) chk("R11", "disabled rcv/pins", rcv_o | sep_dp_o | sep_dm_o, 1'b0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule